// File: doc/BRIEF.md
# Keyboard and Cassette Control Port

This block is a parallel I/O port with fixed directions. It serves a keyboard matrix and a cassette interface. A CPU reaches it through four byte-wide registers in a small window of the I/O address space. The first register is a general latch that can be written and read back, and it drives a byte of output pins. The second register is an input. A read of it returns, in the same cycle, the eight key lines of the matrix row that is selected at that moment. The third register is an output latch. Its low nibble picks the matrix row, and its upper bits drive the cassette motor, the cassette write level, the caps LED and the key-click line.

The fourth address is a command register that software can only write. One command byte sets or clears a single bit of the output latch, chosen by a 3-bit index. Software can therefore flip the cassette or LED controls without first reading the latch and writing it back.

The CPU side is a plain register bus: one write strobe, an address, write data, and read data that is a combinational function of the address. Every access completes in a single cycle. There is no back-pressure, so there is no valid/ready handshake. The key lines and the control pins are level signals.

Top module: `kbio_port`

## Requirements
- R1: While reset is asserted, and after it is released, the general latch and the control latch both hold 0x00. All control pins and the row select are therefore 0.
- R2: A write to offset 0 (address BASE, default 0xA8) loads the general latch on the clock edge. From the next cycle, `port_a_q` and a read of offset 0 return the written byte.
- R3: A read of offset 1 returns `key_cols_n` unchanged in the same cycle, with no register in the path. The key lines are active low.
- R4: A write to offset 2 loads the control latch on the clock edge. A read of offset 2 returns the latched value.
- R5: The control latch bits map to pins as follows. Bits 3..0 drive `row_sel`. Bit 4 drives `cas_motor_off` (1 = motor off). Bit 5 drives `cas_wr_level` (1 = high). Bit 6 drives `caps_led_off` (1 = LED off). Bit 7 drives `click_out` (1 = high).
- R6: A write to offset 3 with data bit 7 = 0 stores data bit 0 into the control-latch bit whose index is given by data bits 3..1. All other bits of the latch are unchanged. Data bits 6..4 have no effect.
- R7: A write to offset 3 with data bit 7 = 1 leaves the control latch unchanged.
- R8: A read of offset 3, or of any address outside the four-address window, returns 0xFF.
- R9: Writes to offset 1, or to addresses outside the window, change neither latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | I/O address of the current access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| key_cols_n | input | 8 | Key lines of the selected matrix row, active low |
| port_a_q | output | 8 | Contents of the general latch |
| row_sel | output | 4 | Keyboard matrix row select |
| cas_motor_off | output | 1 | Cassette motor control, 1 = off |
| cas_wr_level | output | 1 | Cassette write signal level |
| caps_led_off | output | 1 | Caps LED control, 1 = off |
| click_out | output | 1 | 1-bit key-click output |

## Verification
A corrupted control latch shows on the row select and on the four control pins in the cycle that follows the faulty write. A readback of offset 2 shows the same corruption, so a read of that offset catches it too. A command that decodes the wrong index, or that touches a neighbouring bit, changes a pin other than the one addressed. The bench compares every pin after each command, so such a fault is reported one cycle after the write. A decode fault that lets a stray write reach a latch also shows on the pins a cycle later. A fault in the read-mux selection appears in the same cycle as the read.

// File: rtl/kbio_pkg.sv
package kbio_pkg;
  typedef enum logic [1:0] {
    SEL_GEN  = 2'd0,
    SEL_KEYS = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_CMD  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     hit;
    reg_sel_e sel;
  } dec_t;
endpackage

// File: rtl/kbio_decode.sv
module kbio_decode
  import kbio_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter logic [7:0]  BASE   = 8'hA8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output dec_t              dec,
  output logic              wr_gen,
  output logic              wr_ctrl,
  output logic              wr_cmd
);
  localparam logic [ADDR_W-1:0] BASE_W = ADDR_W'(BASE);

  always_comb begin
    dec.hit = (addr[ADDR_W-1:2] == BASE_W[ADDR_W-1:2]);
    dec.sel = reg_sel_e'(addr[1:0]);
  end

  assign wr_gen  = wr && dec.hit && (dec.sel == SEL_GEN);
  assign wr_ctrl = wr && dec.hit && (dec.sel == SEL_CTRL);
  assign wr_cmd  = wr && dec.hit && (dec.sel == SEL_CMD);
endmodule

// File: rtl/kbio_ctrl_latch.sv
module kbio_ctrl_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_cmd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q
);
  localparam int IDX_W = $clog2(DATA_W);

  logic             cmd_ok;
  logic [IDX_W-1:0] cmd_idx;

  assign cmd_ok  = wr_cmd && !wdata[DATA_W-1];
  assign cmd_idx = wdata[IDX_W:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (wr_ctrl)
      ctrl_q <= wdata;
    else if (cmd_ok)
      ctrl_q[cmd_idx] <= wdata[0];
  end

  // R6: a command touches at most one bit, and the chosen bit takes the value
  p_cmd_single_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !wdata[DATA_W-1]) |=> ($countones(ctrl_q ^ $past(ctrl_q)) <= 1));
  p_cmd_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !wdata[DATA_W-1]) |=> (ctrl_q[$past(wdata[IDX_W:1])] == $past(wdata[0])));
  // R7: a command with the top bit set is discarded
  p_cmd_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && wdata[DATA_W-1]) |=> $stable(ctrl_q));
  // R9: without a write to this latch, it holds
  p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ctrl && !wr_cmd) |=> $stable(ctrl_q));
  // R1: reset clears the latch
  p_ctrl_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (ctrl_q == '0));
endmodule

// File: rtl/kbio_rdmux.sv
module kbio_rdmux
  import kbio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  dec_t              dec,
  input  logic [DATA_W-1:0] gen_q,
  input  logic [DATA_W-1:0] ctrl_q,
  input  logic [DATA_W-1:0] keys_n,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '1;
    if (dec.hit) begin
      unique case (dec.sel)
        SEL_GEN:  rdata = gen_q;
        SEL_KEYS: rdata = keys_n;
        SEL_CTRL: rdata = ctrl_q;
        SEL_CMD:  rdata = '1;
      endcase
    end
  end
endmodule

// File: rtl/kbio_port.sv
module kbio_port
  import kbio_pkg::*;
#(
  parameter int         ADDR_W = 8,
  parameter int         DATA_W = 8,
  parameter int         ROW_W  = 4,
  parameter logic [7:0] BASE   = 8'hA8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] key_cols_n,
  output logic [DATA_W-1:0] port_a_q,
  output logic [ROW_W-1:0]  row_sel,
  output logic              cas_motor_off,
  output logic              cas_wr_level,
  output logic              caps_led_off,
  output logic              click_out
);
  localparam int CTL_LO = ROW_W;

  dec_t              dec;
  logic              wr_gen, wr_ctrl, wr_cmd;
  logic [DATA_W-1:0] gen_q, ctrl_q;

  kbio_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .dec(dec),
    .wr_gen(wr_gen), .wr_ctrl(wr_ctrl), .wr_cmd(wr_cmd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gen_q <= '0;
    else if (wr_gen) gen_q <= bus_wdata;
  end

  kbio_ctrl_latch #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_cmd(wr_cmd),
    .wdata(bus_wdata), .ctrl_q(ctrl_q)
  );

  kbio_rdmux #(.DATA_W(DATA_W)) u_rd (
    .dec(dec), .gen_q(gen_q), .ctrl_q(ctrl_q), .keys_n(key_cols_n),
    .rdata(bus_rdata)
  );

  assign port_a_q      = gen_q;
  assign row_sel       = ctrl_q[ROW_W-1:0];
  assign cas_motor_off = ctrl_q[CTL_LO];
  assign cas_wr_level  = ctrl_q[CTL_LO+1];
  assign caps_led_off  = ctrl_q[CTL_LO+2];
  assign click_out     = ctrl_q[CTL_LO+3];

  // R3: key-row reads pass the input straight through
  p_keys_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(BASE) + ADDR_W'(1)) |-> (bus_rdata == key_cols_n));
  // R2: the general latch takes the written byte
  p_gen_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(BASE)) |=> (port_a_q == $past(bus_wdata)));
  // R9: the general latch holds when not addressed
  p_gen_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADDR_W'(BASE)) |=> $stable(port_a_q));
  // R8: command address reads back all ones
  p_cmd_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(BASE) + ADDR_W'(3)) |-> (bus_rdata == '1));
  // R1: reset clears the general latch
  p_gen_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (port_a_q == '0));
endmodule

// File: tb/kbio_port_test.sv
module kbio_port_test;
  typedef struct {
    string      req;
    int         src;
    logic [7:0] exp;
  } item_t;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] key_cols_n = 8'hFF;
  logic [7:0] port_a_q;
  logic [3:0] row_sel;
  logic       cas_motor_off, cas_wr_level, caps_led_off, click_out;

  item_t q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;
  logic [7:0] exp_a = 8'h00;
  logic [7:0] exp_c = 8'h00;

  always #4 clk = ~clk;

  kbio_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .key_cols_n(key_cols_n),
    .port_a_q(port_a_q), .row_sel(row_sel), .cas_motor_off(cas_motor_off),
    .cas_wr_level(cas_wr_level), .caps_led_off(caps_led_off), .click_out(click_out)
  );

  // monitor: pops expectations and compares with what the ports show now
  initial begin
    forever begin
      wait (q.size() != 0);
      begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        case (it.src)
          0:       act = bus_rdata;
          1:       act = port_a_q;
          default: act = {click_out, caps_led_off, cas_wr_level, cas_motor_off, row_sel};
        endcase
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %02h expected %02h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic push(input string req, input int src, input logic [7:0] exp);
    item_t it;
    it.req = req; it.src = src; it.exp = exp;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic read_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    push(req, 0, exp);
  endtask

  task automatic state_chk(input string req);
    push({req, " pins"}, 2, exp_c);
    push({req, " latchA"}, 1, exp_a);
  endtask

  task automatic cmd(input logic [7:0] d);
    bus_write(8'hAB, d);
    if (!d[7]) exp_c[d[3:1]] = d[0];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    state_chk("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    state_chk("R1 after reset");
    read_chk("R1 read A", 8'hA8, 8'h00);
    read_chk("R1 read C", 8'hAA, 8'h00);

    bus_write(8'hA8, 8'h5A); exp_a = 8'h5A;
    state_chk("R2 write A");
    read_chk("R2 read A", 8'hA8, 8'h5A);

    key_cols_n = 8'hFE;
    read_chk("R3 keys FE", 8'hA9, 8'hFE);
    key_cols_n = 8'h7F; #1;
    push("R3 keys 7F same cycle", 0, 8'h7F);

    bus_write(8'hAA, 8'h93); exp_c = 8'h93;
    state_chk("R4 R5 write C 93");
    read_chk("R4 read C", 8'hAA, 8'h93);
    bus_write(8'hAA, 8'h6C); exp_c = 8'h6C;
    state_chk("R5 write C 6C");

    cmd(8'h0B); state_chk("R6 set bit5");
    cmd(8'h08); state_chk("R6 clear bit4");
    cmd(8'h71); state_chk("R6 dont-care bits set bit0");
    cmd(8'h0F); state_chk("R6 set bit7");
    cmd(8'h0C); state_chk("R6 clear bit6");
    read_chk("R6 read C", 8'hAA, exp_c);

    cmd(8'h80); state_chk("R7 ignored clear bit0");
    cmd(8'h8F); state_chk("R7 ignored set bit7");
    cmd(8'hFE); state_chk("R7 ignored 0xFE");

    read_chk("R8 read cmd addr", 8'hAB, 8'hFF);
    read_chk("R8 read outside", 8'h10, 8'hFF);
    read_chk("R8 read AC", 8'hAC, 8'hFF);

    bus_write(8'hA9, 8'h00); state_chk("R9 write B");
    bus_write(8'hAC, 8'h00); state_chk("R9 write AC");
    bus_write(8'hA4, 8'h00); state_chk("R9 write A4");
    bus_write(8'h2A, 8'h00); state_chk("R9 write 2A");

    @(negedge clk); rst_n = 0; exp_a = 0; exp_c = 0;
    @(negedge clk);
    state_chk("R1 second reset");
    rst_n = 1;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule